// File: doc/BRIEF.md
# Audio Sample FIFO Pair with Sticky Error Status

This block sits in the sample path of an audio codec. It buffers samples in two directions. In the playback direction the host pushes bytes and the DAC side pulls them. In the capture direction the ADC side pushes bytes and the host pulls them. Each direction has its own 16-entry, 8-bit FIFO with single-cycle push and pop. Each FIFO shows its full and empty state on a port.

Neither FIFO stalls its producer or its consumer. A push into a full FIFO is dropped, and a pull from an empty FIFO is missed. Each such event raises a sticky error flag. All four error flags appear in one status byte, together with three interrupt-pending inputs. The host reads this byte combinationally and clears flags by writing zeros to them. When the host pulls from an empty capture FIFO, it receives the last byte it validly pulled.

Top module: `audio_fifo_pair`

## Requirements
- R1: After reset the status byte reads 0x00, both FIFOs report empty and not full, and the capture read data is 0x00.
- R2: Each FIFO holds 16 bytes in first-in first-out order. The full output is high exactly when 16 bytes are held, and the empty output is high exactly when none are held.
- R3: A host playback write while the playback FIFO is full is discarded and sets status bit 1.
- R4: A DAC request while the playback FIFO is empty delivers no sample and sets status bit 0.
- R5: An ADC sample delivered while the capture FIFO is full is discarded and sets status bit 2.
- R6: A host capture read while the capture FIFO is empty sets status bit 3. That read returns the byte of the most recent successful capture read, or 0x00 if there has been none.
- R7: Status bits 0 to 3 are sticky. A status write with a 0 in one of these bits clears that bit, and a 1 leaves it unchanged. A set condition in the same cycle as a clear wins.
- R8: Status bits 4, 5 and 6 mirror the playback-count, capture-count and timer interrupt inputs in the same cycle. The any-interrupt output is their OR.
- R9: Status bit 7 always reads 0, even after a status write with bit 7 set.
- R10: The full and empty decisions use the state held before the cycle. A write to a full FIFO is dropped even if a pop happens in the same cycle. A pop from an empty FIFO misses even if a push happens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pb_wr_i | input | 1 | Host playback write strobe |
| pb_wdata_i | input | 8 | Host playback write byte |
| dac_req_i | input | 1 | DAC sample request (pop) |
| dac_data_o | output | 8 | Playback head byte for the DAC |
| pb_full_o | output | 1 | Playback FIFO full |
| pb_empty_o | output | 1 | Playback FIFO empty |
| adc_wr_i | input | 1 | ADC sample strobe (push) |
| adc_data_i | input | 8 | ADC sample byte |
| cap_rd_i | input | 1 | Host capture read strobe |
| cap_rdata_o | output | 8 | Capture byte to the host |
| cap_full_o | output | 1 | Capture FIFO full |
| cap_empty_o | output | 1 | Capture FIFO empty |
| pb_irq_i | input | 1 | Playback count interrupt pending |
| cap_irq_i | input | 1 | Capture count interrupt pending |
| tmr_irq_i | input | 1 | Timer interrupt pending |
| stat_wr_i | input | 1 | Status byte write strobe |
| stat_wdata_i | input | 8 | Status byte write data |
| stat_rdata_o | output | 8 | Status byte read data |
| irq_o | output | 1 | Any interrupt pending |

## Verification
Four outputs are combinational and valid in the same cycle as their strobe, before the clock edge: the head bytes, the capture fallback byte and the interrupt bits of the status byte. The error flags and the full and empty outputs change on the edge that samples the triggering strobe, so they become valid one cycle later. The bench drives inputs 1 ns after a rising edge. It checks the combinational results before the next edge, and checks the registered results 1 ns after that edge. A bench model of both FIFOs, using the pre-cycle occupancy, supplies every expected value.

// File: rtl/audio_fifo_pkg.sv
package audio_fifo_pkg;
  localparam int STAT_W = 8;
  localparam int NERR   = 4;
  // status bit positions
  localparam int B_PB_UNDER  = 0;
  localparam int B_PB_OVER   = 1;
  localparam int B_CAP_OVER  = 2;
  localparam int B_CAP_UNDER = 3;
  localparam int B_PB_IRQ    = 4;
  localparam int B_CAP_IRQ   = 5;
  localparam int B_TMR_IRQ   = 6;
endpackage

// File: rtl/afp_fifo.sv
module afp_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]    cnt_q;
  logic             push_ok, pop_ok;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i & ~full_o;   // full judged on pre-cycle state
  assign pop_ok  = pop_i & ~empty_o;
  assign data_o  = mem_q[rd_ptr_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= nxt(wr_ptr_q);
      if (pop_ok)  rd_ptr_q <= nxt(rd_ptr_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  a_r2_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  a_r2_full_empty_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));
  a_r10_full_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && push_i && !pop_i |=> full_o);
  a_r10_empty_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o && pop_i && !push_i |=> empty_o);
endmodule

// File: rtl/afp_err_flags.sv
module afp_err_flags #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q <= 1'b0;
      else         flag_q <= set_i[i] | (flag_q & ~clr_i[i]);  // set wins
    end
    assign flags_o[i] = flag_q;

    a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flag_q && !clr_i[i] |=> flag_q);
    a_r7_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> flags_o[i]);
  end
endmodule

// File: rtl/audio_fifo_pair.sv
module audio_fifo_pair
  import audio_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pb_wr_i,
  input  logic [WIDTH-1:0] pb_wdata_i,
  input  logic             dac_req_i,
  output logic [WIDTH-1:0] dac_data_o,
  output logic             pb_full_o,
  output logic             pb_empty_o,
  input  logic             adc_wr_i,
  input  logic [WIDTH-1:0] adc_data_i,
  input  logic             cap_rd_i,
  output logic [WIDTH-1:0] cap_rdata_o,
  output logic             cap_full_o,
  output logic             cap_empty_o,
  input  logic             pb_irq_i,
  input  logic             cap_irq_i,
  input  logic             tmr_irq_i,
  input  logic             stat_wr_i,
  input  logic [STAT_W-1:0] stat_wdata_i,
  output logic [STAT_W-1:0] stat_rdata_o,
  output logic             irq_o
);
  logic [WIDTH-1:0] cap_head;
  logic [WIDTH-1:0] last_q;
  logic [NERR-1:0]  err_set, err_clr, err_q;

  afp_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_pb_fifo (
    .clk_i, .rst_ni,
    .push_i (pb_wr_i),  .data_i (pb_wdata_i),
    .pop_i  (dac_req_i), .data_o (dac_data_o),
    .full_o (pb_full_o), .empty_o (pb_empty_o)
  );

  afp_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_cap_fifo (
    .clk_i, .rst_ni,
    .push_i (adc_wr_i), .data_i (adc_data_i),
    .pop_i  (cap_rd_i), .data_o (cap_head),
    .full_o (cap_full_o), .empty_o (cap_empty_o)
  );

  // last byte validly handed to the host
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      last_q <= '0;
    else if (cap_rd_i && !cap_empty_o) last_q <= cap_head;
  end
  assign cap_rdata_o = cap_empty_o ? last_q : cap_head;

  always_comb begin
    err_set              = '0;
    err_set[B_PB_UNDER]  = dac_req_i & pb_empty_o;
    err_set[B_PB_OVER]   = pb_wr_i   & pb_full_o;
    err_set[B_CAP_OVER]  = adc_wr_i  & cap_full_o;
    err_set[B_CAP_UNDER] = cap_rd_i  & cap_empty_o;
  end
  assign err_clr = {NERR{stat_wr_i}} & ~stat_wdata_i[NERR-1:0];

  afp_err_flags #(.N(NERR)) u_flags (
    .clk_i, .rst_ni,
    .set_i (err_set), .clr_i (err_clr), .flags_o (err_q)
  );

  always_comb begin
    stat_rdata_o             = '0;
    stat_rdata_o[NERR-1:0]   = err_q;
    stat_rdata_o[B_PB_IRQ]   = pb_irq_i;
    stat_rdata_o[B_CAP_IRQ]  = cap_irq_i;
    stat_rdata_o[B_TMR_IRQ]  = tmr_irq_i;
  end
  assign irq_o = pb_irq_i | cap_irq_i | tmr_irq_i;

  a_r4_pb_under: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_req_i && pb_empty_o |=> stat_rdata_o[B_PB_UNDER]);
  a_r3_pb_over: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pb_wr_i && pb_full_o |=> stat_rdata_o[B_PB_OVER] && pb_full_o == !$past(dac_req_i));
  a_r5_cap_over: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_wr_i && cap_full_o |=> stat_rdata_o[B_CAP_OVER]);
  a_r6_cap_under: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_rd_i && cap_empty_o |=> stat_rdata_o[B_CAP_UNDER] && $stable(last_q));
  a_r9_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_wr_i |=> !stat_rdata_o[STAT_W-1]);
endmodule

// File: tb/tb_audio_fifo_pair.sv
`timescale 1ns/1ps
module tb_audio_fifo_pair;
  logic clk = 0, rst_n = 0;
  logic pb_wr = 0, dac_req = 0, adc_wr = 0, cap_rd = 0, stat_wr = 0;
  logic pb_irq = 0, cap_irq = 0, tmr_irq = 0;
  logic [7:0] pb_wdata = 0, adc_data = 0, stat_wdata = 0;
  logic [7:0] dac_data, cap_rdata, stat_rdata;
  logic pb_full, pb_empty, cap_full, cap_empty, irq;

  int checks = 0, errors = 0;
  logic [7:0] pbq[$];
  logic [7:0] capq[$];
  logic [7:0] last_m = 0;
  logic [3:0] flags_m = 0;

  always #10 clk = ~clk;  // 50 MHz

  audio_fifo_pair dut (
    .clk_i(clk), .rst_ni(rst_n),
    .pb_wr_i(pb_wr), .pb_wdata_i(pb_wdata), .dac_req_i(dac_req), .dac_data_o(dac_data),
    .pb_full_o(pb_full), .pb_empty_o(pb_empty),
    .adc_wr_i(adc_wr), .adc_data_i(adc_data), .cap_rd_i(cap_rd), .cap_rdata_o(cap_rdata),
    .cap_full_o(cap_full), .cap_empty_o(cap_empty),
    .pb_irq_i(pb_irq), .cap_irq_i(cap_irq), .tmr_irq_i(tmr_irq),
    .stat_wr_i(stat_wr), .stat_wdata_i(stat_wdata), .stat_rdata_o(stat_rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_state(input string req);
    chk({req, " flags"}, 32'(stat_rdata[3:0]), 32'(flags_m));
    chk({req, " pb_full"}, 32'(pb_full), 32'(pbq.size() == 16));
    chk({req, " pb_empty"}, 32'(pb_empty), 32'(pbq.size() == 0));
    chk({req, " cap_full"}, 32'(cap_full), 32'(capq.size() == 16));
    chk({req, " cap_empty"}, 32'(cap_empty), 32'(capq.size() == 0));
  endtask

  // one clock of stimulus, starting 1ns after a rising edge
  task automatic step(input string req, input bit pw, input logic [7:0] pd, input bit dr,
                      input bit aw, input logic [7:0] ad, input bit cr,
                      input bit sw, input logic [7:0] sd);
    bit pb_pop, pb_push, cap_pop, cap_push;
    logic [3:0] set, clr;
    pb_wr = pw; pb_wdata = pd; dac_req = dr; adc_wr = aw; adc_data = ad;
    cap_rd = cr; stat_wr = sw; stat_wdata = sd;
    #1;
    if (dr && pbq.size() > 0) chk({req, " dac_data"}, 32'(dac_data), 32'(pbq[0]));
    if (cr) chk({req, " cap_rdata"}, 32'(cap_rdata),
                32'((capq.size() > 0) ? capq[0] : last_m));
    pb_pop   = dr && pbq.size() > 0;
    pb_push  = pw && pbq.size() < 16;
    cap_pop  = cr && capq.size() > 0;
    cap_push = aw && capq.size() < 16;
    set = {cr && capq.size() == 0, aw && capq.size() == 16,
           pw && pbq.size() == 16, dr && pbq.size() == 0};
    clr = sw ? ~sd[3:0] : 4'h0;
    flags_m = set | (flags_m & ~clr);
    if (pb_pop) void'(pbq.pop_front());
    if (pb_push) pbq.push_back(pd);
    if (cap_pop) last_m = capq.pop_front();
    if (cap_push) capq.push_back(ad);
    @(posedge clk); #1;
    pb_wr = 0; dac_req = 0; adc_wr = 0; cap_rd = 0; stat_wr = 0;
    chk_state(req);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    // R1 reset state
    chk("R1 status", 32'(stat_rdata), 32'h0);
    chk("R1 cap_rdata", 32'(cap_rdata), 32'h0);
    chk_state("R1");

    // R2/R3 fill playback past full
    for (int i = 0; i < 17; i++) step("R2 R3 pb fill", 1, 8'(8'hA0 + i), 0, 0, 0, 0, 0, 0);
    chk("R3 pb over flag", 32'(stat_rdata[1]), 32'h1);
    // R2 drain in order, R4 one extra request
    for (int i = 0; i < 17; i++) step("R2 R4 pb drain", 0, 0, 1, 0, 0, 0, 0, 0);
    chk("R4 pb under flag", 32'(stat_rdata[0]), 32'h1);

    // R7 write of ones changes nothing, zeros clear
    step("R7 write ones", 0, 0, 0, 0, 0, 0, 1, 8'hFF);
    chk("R7 kept", 32'(stat_rdata[1:0]), 32'h3);
    step("R7 write zeros", 0, 0, 0, 0, 0, 0, 1, 8'hFC);
    chk("R7 cleared", 32'(stat_rdata[1:0]), 32'h0);

    // R6 empty read before any valid byte returns 0
    step("R6 empty read", 0, 0, 0, 0, 0, 1, 0, 0);
    chk("R6 cu flag", 32'(stat_rdata[3]), 32'h1);
    // R5 fill capture past full
    for (int i = 0; i < 17; i++) step("R2 R5 cap fill", 0, 0, 0, 1, 8'(8'h30 + 3 * i), 0, 0, 0);
    chk("R5 co flag", 32'(stat_rdata[2]), 32'h1);
    for (int i = 0; i < 16; i++) step("R2 cap drain", 0, 0, 0, 0, 0, 1, 0, 0);
    step("R6 last valid", 0, 0, 0, 0, 0, 1, 0, 0);
    step("R6 last valid again", 0, 0, 0, 0, 0, 1, 0, 0);
    // R7 set beats clear in same cycle
    step("R7 set wins", 0, 0, 0, 0, 0, 1, 1, 8'h00);
    chk("R7 cu kept", 32'(stat_rdata[3]), 32'h1);
    chk("R7 co cleared", 32'(stat_rdata[2]), 32'h0);
    step("R7 clear all", 0, 0, 0, 0, 0, 0, 1, 8'h00);

    // R10 full: write plus pop in same cycle still drops
    for (int i = 0; i < 16; i++) step("R10 pb fill", 1, 8'(8'h11 * i), 0, 0, 0, 0, 0, 0);
    step("R10 full write+pop", 1, 8'hEE, 1, 1, 8'h5A, 1, 0, 0);
    chk("R10 po", 32'(stat_rdata[1]), 32'h1);
    for (int i = 0; i < 15; i++) step("R10 pb drain", 0, 0, 1, 0, 0, 0, 0, 0);
    // R10 empty: pop plus push in same cycle still misses
    step("R10 empty pop+push", 1, 8'h77, 1, 1, 8'h66, 1, 0, 0);
    chk("R10 pu", 32'(stat_rdata[0]), 32'h1);
    step("R10 drain one", 0, 0, 1, 0, 0, 1, 0, 0);
    step("R10 drain two", 0, 0, 0, 0, 0, 1, 1, 8'h00);

    // R8 interrupt sweep, R9 reserved bit
    for (int m = 0; m < 8; m++) begin
      {tmr_irq, cap_irq, pb_irq} = 3'(m);
      #1;
      chk("R8 irq bits", 32'(stat_rdata[6:4]), 32'(m));
      chk("R8 irq_o", 32'(irq), 32'(m != 0));
      chk("R9 bit7", 32'(stat_rdata[7]), 32'h0);
      @(posedge clk); #1;
    end
    {tmr_irq, cap_irq, pb_irq} = 3'b0;
    step("R9 write bit7", 0, 0, 0, 0, 0, 0, 1, 8'h8F);
    chk("R9 bit7 after write", 32'(stat_rdata[7]), 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule